// File: doc/BRIEF.md
# Accumulator ALU and Rotator

This block is the 8-bit arithmetic and logic stage of an accumulator machine. It decodes an instruction byte and handles three groups of opcodes. The first is the two-operand group: add, add with carry, subtract, subtract with borrow, AND, XOR, OR and compare. These come in a register-source form and an immediate form, and both forms share one 3-bit operation field. The second group is the four accumulator rotates. The third is complement-accumulator, set-carry and complement-carry.

For the register-source form, the block picks the second operand itself from three places: a packed bank of six general registers, a memory byte and the accumulator. The caller fetches these values and presents them on the block's inputs. The block holds the five status flags (zero, sign, parity, carry and auxiliary carry) in its own register. The stored carry is the carry input for add-with-carry, subtract-with-borrow, the rotates through carry and complement-carry.

When `op_valid` is high for a cycle, the new accumulator value and its write strobe appear at the next clock edge. The updated flags appear at that same edge. Opcodes outside the groups above are ignored.

Top module: `alu8_unit`

## Requirements
- R1: Synchronous active-high `rst` clears `result`, `acc_we` and all five flags to 0.
- R2: In the register-source form `10oooSSS`, the source code SSS selects the operand. Codes 0 to 5 select byte k of `src_regs` (bits 8k+7..8k). Code 6 selects `mem_data` and code 7 selects `acc_in`.
- R3: The immediate form `11ooo110` uses `imm_data` as the operand and gives the field ooo the same meaning as in R2.
- R4: Field 000 adds the operand to the accumulator and field 001 also adds the stored carry. Carry is the carry out of bit 7. Auxiliary carry is the carry out of bit 3.
- R5: Field 010 subtracts the operand and field 011 also subtracts the stored carry. Carry is set on a borrow out of bit 7. Auxiliary carry is set on a borrow out of bit 3.
- R6: Fields 100, 101 and 110 give AND, XOR and OR, and clear both carry and auxiliary carry.
- R7: For every two-operand opcode, zero, sign (bit 7) and parity are taken from the 8-bit difference or result. Parity is 1 when the number of ones is even.
- R8: Field 111 (compare) sets every flag exactly as subtract would. It raises no `acc_we` and leaves `result` unchanged.
- R9: Opcodes 0x07, 0x0F, 0x17 and 0x1F rotate the accumulator left circular, right circular, left through carry and right through carry. The bit shifted out goes to carry, and the other four flags are unchanged.
- R10: Opcode 0x2F writes the bitwise complement of `acc_in` and changes no flag.
- R11: Opcode 0x37 sets carry and 0x3F inverts it. Both leave the other flags and `result` unchanged and raise no `acc_we`.
- R12: All outputs are registered and change only at the clock edge that follows a cycle with `op_valid` high. `acc_we` is high for exactly that one cycle, and only for opcodes that write the accumulator.
- R13: Any other opcode, for example 0x00, 0x76, 0x47 or 0xC7, leaves `result` and the flags unchanged and raises no `acc_we`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Execute the presented opcode this cycle |
| opcode | input | 8 | Instruction byte |
| acc_in | input | 8 | Current accumulator value |
| src_regs | input | 48 | Six general registers, source code k in byte k |
| mem_data | input | 8 | Memory operand byte |
| imm_data | input | 8 | Immediate operand byte |
| result | output | 8 | New accumulator value |
| acc_we | output | 1 | Accumulator write strobe for `result` |
| flag_z | output | 1 | Zero flag |
| flag_s | output | 1 | Sign flag |
| flag_p | output | 1 | Even-parity flag |
| flag_cy | output | 1 | Carry / borrow flag |
| flag_ac | output | 1 | Auxiliary carry / borrow flag |

## Verification
Every result, write strobe and flag of an operation is due exactly one rising edge after the cycle in which `op_valid` and the operands are held. An idle cycle must show no change at all. The bench changes its inputs on the falling edge and reads the outputs on the next falling edge, so exactly one register stage lies between stimulus and sample. The table runs its vectors back to back so that the stored carry from one step feeds the next. The directed tests insert an idle cycle and a reset between operations to check that nothing moves when `op_valid` is low and that the stored flags are cleared.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int NUM_REGS = 6;
  localparam int SRC_W    = 3;
  localparam int NUM_SRC  = 1 << SRC_W;
  localparam int SEL_MEM  = 6;

  typedef enum logic [2:0] {
    OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_AND, OP_XOR, OP_OR, OP_CMP
  } aluop_e;

  typedef enum logic [2:0] {
    K_NONE, K_ALU, K_ROT, K_CMA, K_STC, K_CMC
  } kind_e;

  typedef enum logic [1:0] {
    ROT_LC, ROT_RC, ROT_LT, ROT_RT
  } rot_e;

  typedef struct packed {
    logic z;
    logic s;
    logic p;
    logic cy;
    logic ac;
  } flags_t;

  typedef struct packed {
    kind_e              kind;
    aluop_e             op;
    rot_e               rot;
    logic               use_imm;
    logic [SRC_W-1:0]   src;
  } dec_t;

endpackage

// File: rtl/alu8_decode.sv
module alu8_decode
  import alu8_pkg::*;
(
  input  logic [7:0] opcode,
  output dec_t       dec
);

  always_comb begin
    dec.kind    = K_NONE;
    dec.op      = aluop_e'(opcode[5:3]);
    dec.rot     = rot_e'(opcode[4:3]);
    dec.use_imm = 1'b0;
    dec.src     = opcode[2:0];
    if (opcode[7:6] == 2'b10) begin
      dec.kind = K_ALU;
    end else if (opcode[7:6] == 2'b11 && opcode[2:0] == 3'b110) begin
      dec.kind    = K_ALU;
      dec.use_imm = 1'b1;
    end else if (opcode[7:5] == 3'b000 && opcode[2:0] == 3'b111) begin
      dec.kind = K_ROT;
    end else begin
      case (opcode)
        8'h2F:   dec.kind = K_CMA;
        8'h37:   dec.kind = K_STC;
        8'h3F:   dec.kind = K_CMC;
        default: dec.kind = K_NONE;
      endcase
    end
  end

endmodule

// File: rtl/alu8_srcsel.sv
module alu8_srcsel
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [NUM_REGS*DATA_W-1:0] src_regs,
  input  logic [DATA_W-1:0]          mem_data,
  input  logic [DATA_W-1:0]          acc_in,
  input  logic [DATA_W-1:0]          imm_data,
  input  logic [SRC_W-1:0]           sel,
  input  logic                       use_imm,
  output logic [DATA_W-1:0]          operand
);

  logic [DATA_W-1:0] choice [NUM_SRC];

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    if (k < NUM_REGS) begin : g_reg
      assign choice[k] = src_regs[k*DATA_W +: DATA_W];
    end else if (k == SEL_MEM) begin : g_mem
      assign choice[k] = mem_data;
    end else begin : g_acc
      assign choice[k] = acc_in;
    end
  end

  assign operand = use_imm ? imm_data : choice[sel];

endmodule

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  input  aluop_e            op,
  output logic [DATA_W-1:0] res,
  output flags_t            fl
);

  localparam int HALF = DATA_W / 2;

  logic [DATA_W:0] wide;
  logic [HALF:0]   low;
  logic            extra;

  always_comb begin
    extra = 1'b0;
    wide  = '0;
    low   = '0;
    case (op)
      OP_ADD, OP_ADC: begin
        extra = (op == OP_ADC) & cin;
        wide  = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, extra};
        low   = {1'b0, a[HALF-1:0]} + {1'b0, b[HALF-1:0]} + {{HALF{1'b0}}, extra};
      end
      OP_SUB, OP_SBB, OP_CMP: begin
        extra = (op == OP_SBB) & cin;
        wide  = {1'b0, a} - {1'b0, b} - {{DATA_W{1'b0}}, extra};
        low   = {1'b0, a[HALF-1:0]} - {1'b0, b[HALF-1:0]} - {{HALF{1'b0}}, extra};
      end
      OP_AND:  wide = {1'b0, a & b};
      OP_XOR:  wide = {1'b0, a ^ b};
      OP_OR:   wide = {1'b0, a | b};
      default: wide = '0;
    endcase
    res   = wide[DATA_W-1:0];
    fl.cy = wide[DATA_W];
    fl.ac = low[HALF];
    fl.z  = (res == '0);
    fl.s  = res[DATA_W-1];
    fl.p  = ~^res;
  end

endmodule

// File: rtl/alu8_rotate.sv
module alu8_rotate
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic              cin,
  input  rot_e              mode,
  output logic [DATA_W-1:0] res,
  output logic              cout
);

  always_comb begin
    case (mode)
      ROT_LC: begin
        res  = {a[DATA_W-2:0], a[DATA_W-1]};
        cout = a[DATA_W-1];
      end
      ROT_RC: begin
        res  = {a[0], a[DATA_W-1:1]};
        cout = a[0];
      end
      ROT_LT: begin
        res  = {a[DATA_W-2:0], cin};
        cout = a[DATA_W-1];
      end
      default: begin
        res  = {cin, a[DATA_W-1:1]};
        cout = a[0];
      end
    endcase
  end

endmodule

// File: rtl/alu8_unit.sv
module alu8_unit
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       op_valid,
  input  logic [7:0]                 opcode,
  input  logic [DATA_W-1:0]          acc_in,
  input  logic [NUM_REGS*DATA_W-1:0] src_regs,
  input  logic [DATA_W-1:0]          mem_data,
  input  logic [DATA_W-1:0]          imm_data,
  output logic [DATA_W-1:0]          result,
  output logic                       acc_we,
  output logic                       flag_z,
  output logic                       flag_s,
  output logic                       flag_p,
  output logic                       flag_cy,
  output logic                       flag_ac
);

  dec_t              dec;
  logic [DATA_W-1:0] operand;
  logic [DATA_W-1:0] ar_res;
  flags_t            ar_fl;
  logic [DATA_W-1:0] rot_res;
  logic              rot_cy;

  flags_t            fl_q, fl_d;
  logic [DATA_W-1:0] res_q, res_d;
  logic              we_q, we_d;

  alu8_decode u_dec (
    .opcode (opcode),
    .dec    (dec)
  );

  alu8_srcsel #(.DATA_W(DATA_W)) u_src (
    .src_regs (src_regs),
    .mem_data (mem_data),
    .acc_in   (acc_in),
    .imm_data (imm_data),
    .sel      (dec.src),
    .use_imm  (dec.use_imm),
    .operand  (operand)
  );

  alu8_arith #(.DATA_W(DATA_W)) u_ar (
    .a   (acc_in),
    .b   (operand),
    .cin (fl_q.cy),
    .op  (dec.op),
    .res (ar_res),
    .fl  (ar_fl)
  );

  alu8_rotate #(.DATA_W(DATA_W)) u_rot (
    .a    (acc_in),
    .cin  (fl_q.cy),
    .mode (dec.rot),
    .res  (rot_res),
    .cout (rot_cy)
  );

  always_comb begin
    fl_d  = fl_q;
    res_d = res_q;
    we_d  = 1'b0;
    if (op_valid) begin
      case (dec.kind)
        K_ALU: begin
          fl_d = ar_fl;
          if (dec.op != OP_CMP) begin
            res_d = ar_res;
            we_d  = 1'b1;
          end
        end
        K_ROT: begin
          res_d   = rot_res;
          we_d    = 1'b1;
          fl_d.cy = rot_cy;
        end
        K_CMA: begin
          res_d = ~acc_in;
          we_d  = 1'b1;
        end
        K_STC:   fl_d.cy = 1'b1;
        K_CMC:   fl_d.cy = ~fl_q.cy;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fl_q  <= '0;
      res_q <= '0;
      we_q  <= 1'b0;
    end else begin
      fl_q  <= fl_d;
      res_q <= res_d;
      we_q  <= we_d;
    end
  end

  assign result  = res_q;
  assign acc_we  = we_q;
  assign flag_z  = fl_q.z;
  assign flag_s  = fl_q.s;
  assign flag_p  = fl_q.p;
  assign flag_cy = fl_q.cy;
  assign flag_ac = fl_q.ac;

endmodule

// File: rtl/alu8_chk.sv
module alu8_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic [7:0]        opcode,
  input logic [DATA_W-1:0] acc_in,
  input logic [DATA_W-1:0] imm_data,
  input logic [DATA_W-1:0] result,
  input logic              acc_we,
  input logic              flag_z,
  input logic              flag_s,
  input logic              flag_p,
  input logic              flag_cy,
  input logic              flag_ac
);

  // R12: write strobe only after a valid cycle
  a_r12_we_after_valid: assert property (@(posedge clk) disable iff (rst)
    acc_we |-> ($past(op_valid) && !$past(rst)));

  // R12: idle cycles change nothing
  a_r12_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(op_valid)) |->
      ($stable({result, flag_z, flag_s, flag_p, flag_cy, flag_ac}) && !acc_we));

  // R8: compare never writes the accumulator
  a_r8_cmp_no_write: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_valid) && ($past(opcode[7:3]) == 5'b10111 || $past(opcode) == 8'hFE))
      |-> (!acc_we && $stable(result)));

  // R5: immediate compare borrow follows unsigned ordering
  a_r5_cpi_borrow: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_valid) && $past(opcode) == 8'hFE)
      |-> (flag_cy == ($past(imm_data) > $past(acc_in))));

  // R6: logical register forms clear both carries
  a_r6_logic_clears: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_valid) && $past(opcode[7:6]) == 2'b10 &&
     $past(opcode[5]) && $past(opcode[5:3]) != 3'b111)
      |-> (!flag_cy && !flag_ac));

  // R7: zero flag agrees with a written two-operand result
  a_r7_zero_matches: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_valid) && $past(opcode[7]) && acc_we)
      |-> (flag_z == (result == '0)));

  // R9: rotates leave the other four flags alone
  a_r9_rot_flags: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_valid) && $past(opcode[7:5]) == 3'b000 && $past(opcode[2:0]) == 3'b111)
      |-> $stable({flag_z, flag_s, flag_p, flag_ac}));

  // R10: complement writes inverted accumulator, flags untouched
  a_r10_cma: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_valid) && $past(opcode) == 8'h2F)
      |-> (result == ~$past(acc_in) && acc_we &&
           $stable({flag_z, flag_s, flag_p, flag_cy, flag_ac})));

  // R11: set-carry forces carry high
  a_r11_stc: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_valid) && $past(opcode) == 8'h37) |-> (flag_cy && !acc_we));

endmodule

bind alu8_unit alu8_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_alu8_unit.sv
module tb_alu8_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [7:0]  acc_in = 8'h00;
  logic [47:0] src_regs = {8'h66, 8'h55, 8'h44, 8'h33, 8'h22, 8'h11};
  logic [7:0]  mem_data = 8'h77;
  logic [7:0]  imm_data = 8'h00;
  logic [7:0]  result;
  logic        acc_we;
  logic        flag_z, flag_s, flag_p, flag_cy, flag_ac;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  alu8_unit dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .opcode(opcode),
    .acc_in(acc_in), .src_regs(src_regs), .mem_data(mem_data),
    .imm_data(imm_data), .result(result), .acc_we(acc_we),
    .flag_z(flag_z), .flag_s(flag_s), .flag_p(flag_p),
    .flag_cy(flag_cy), .flag_ac(flag_ac)
  );

  // {opcode, acc, imm, result, we, z s p cy ac}; run back to back
  localparam int NV = 31;
  localparam logic [37:0] VEC [NV] = '{
    {8'h80, 8'h10, 8'h00, 8'h21, 1'b1, 5'b00100},
    {8'h86, 8'h99, 8'h00, 8'h10, 1'b1, 5'b00011},
    {8'h89, 8'h01, 8'h00, 8'h24, 1'b1, 5'b00100},
    {8'h92, 8'h33, 8'h00, 8'h00, 1'b1, 5'b10100},
    {8'h93, 8'h40, 8'h00, 8'hFC, 1'b1, 5'b01111},
    {8'h9C, 8'h60, 8'h00, 8'h0A, 1'b1, 5'b00101},
    {8'hA5, 8'hF0, 8'h00, 8'h60, 1'b1, 5'b00100},
    {8'hAF, 8'h5A, 8'h00, 8'h00, 1'b1, 5'b10100},
    {8'hB0, 8'h80, 8'h00, 8'h91, 1'b1, 5'b01000},
    {8'hB9, 8'h10, 8'h00, 8'h91, 1'b0, 5'b01111},
    {8'hC6, 8'h7F, 8'h01, 8'h80, 1'b1, 5'b01001},
    {8'hCE, 8'hFF, 8'h00, 8'hFF, 1'b1, 5'b01100},
    {8'hD6, 8'h05, 8'h05, 8'h00, 1'b1, 5'b10100},
    {8'h37, 8'h00, 8'h00, 8'h00, 1'b0, 5'b10110},
    {8'hDE, 8'h00, 8'h00, 8'hFF, 1'b1, 5'b01111},
    {8'hE6, 8'hFF, 8'h0F, 8'h0F, 1'b1, 5'b00100},
    {8'hEE, 8'h0F, 8'hFF, 8'hF0, 1'b1, 5'b01100},
    {8'hF6, 8'h00, 8'h00, 8'h00, 1'b1, 5'b10100},
    {8'hFE, 8'h40, 8'h40, 8'h00, 1'b0, 5'b10100},
    {8'h3F, 8'h00, 8'h00, 8'h00, 1'b0, 5'b10110},
    {8'h07, 8'h81, 8'h00, 8'h03, 1'b1, 5'b10110},
    {8'h0F, 8'h02, 8'h00, 8'h01, 1'b1, 5'b10100},
    {8'h17, 8'h80, 8'h00, 8'h00, 1'b1, 5'b10110},
    {8'h1F, 8'h00, 8'h00, 8'h80, 1'b1, 5'b10100},
    {8'h2F, 8'h3C, 8'h00, 8'hC3, 1'b1, 5'b10100},
    {8'h3F, 8'h00, 8'h00, 8'hC3, 1'b0, 5'b10110},
    {8'h00, 8'h12, 8'h34, 8'hC3, 1'b0, 5'b10110},
    {8'h76, 8'h12, 8'h34, 8'hC3, 1'b0, 5'b10110},
    {8'h47, 8'h12, 8'h34, 8'hC3, 1'b0, 5'b10110},
    {8'hC7, 8'h12, 8'h34, 8'hC3, 1'b0, 5'b10110},
    {8'h17, 8'h00, 8'h00, 8'h01, 1'b1, 5'b10100}
  };

  function automatic string req_of(logic [7:0] op);
    string base;
    if (op[7:6] == 2'b10 || (op[7:6] == 2'b11 && op[2:0] == 3'b110)) begin
      case (op[5:3])
        3'b000, 3'b001: base = "R4";
        3'b010, 3'b011: base = "R5";
        3'b111:         base = "R8";
        default:        base = "R6";
      endcase
      return (op[7:6] == 2'b10) ? {"R2/", base} : {"R3/", base};
    end
    if (op[7:5] == 3'b000 && op[2:0] == 3'b111) return "R9";
    if (op == 8'h2F) return "R10";
    if (op == 8'h37 || op == 8'h3F) return "R11";
    return "R13";
  endfunction

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(string tag, logic [7:0] er, logic ew, logic [4:0] ef);
    chk(tag, "result", result, er);
    chk({tag, "/R12"}, "acc_we", {7'd0, acc_we}, {7'd0, ew});
    chk({tag, "/R7"}, "z,s,p", {5'd0, flag_z, flag_s, flag_p}, {5'd0, ef[4:2]});
    chk(tag, "cy,ac", {6'd0, flag_cy, flag_ac}, {6'd0, ef[1:0]});
  endtask

  initial begin
    logic [37:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk_all("R1", 8'h00, 1'b0, 5'b00000);

    for (int i = 0; i < NV; i++) begin
      v        = VEC[i];
      op_valid = 1'b1;
      opcode   = v[37:30];
      acc_in   = v[29:22];
      imm_data = v[21:14];
      @(negedge clk);
      chk_all(req_of(v[37:30]), v[13:6], v[5], v[4:0]);
    end

    // R12: idle cycle with a live ALU opcode changes nothing
    op_valid = 1'b0;
    opcode   = 8'h80;
    acc_in   = 8'hAA;
    @(negedge clk);
    chk_all("R12", 8'h01, 1'b0, 5'b10100);

    // R1: reset in mid run clears stored state
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk_all("R1", 8'h00, 1'b0, 5'b00000);

    // R4: add with carry after reset sees carry 0, overflows to zero
    op_valid = 1'b1;
    opcode   = 8'h88;
    acc_in   = 8'hEF;
    @(negedge clk);
    chk_all("R2/R4", 8'h00, 1'b1, 5'b10111);

    // R12: strobe drops on the next idle cycle
    op_valid = 1'b0;
    @(negedge clk);
    chk_all("R12", 8'h00, 1'b0, 5'b10111);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule